// File: doc/BRIEF.md
# I2C Transfer Byte Counter with Automatic STOP Request

This block sits beside an I2C protocol engine and keeps a running count of the data bytes moving on the bus. It works the same way when the engine acts as controller or as target. The engine feeds it single-cycle event strobes: a START or repeated START, a strobe for each bit position with the index of that bit inside the byte (0 for the first bit, 8 for the ACK/NACK slot), an address-phase level, an arbitration-lost strobe and a strobe at the end of each byte. From these the block keeps a saturating count that is cleared by every START. The count advances at the second bit of each data byte, so the result of the ACK/NACK bit plays no part.

A programmable threshold is compared with the count. A sticky flag reports that the threshold has been reached. In controller mode the block can also ask the engine to close the transfer: it issues a one-cycle STOP request at the end of the byte that brought the count to the threshold. A two-bit mode field picks the behaviour: `00` does nothing, `01` raises the flag only, `10` raises the flag and also requests the STOP in controller mode, and `11` behaves like `00`.

All inputs are plain control strobes and levels, and all outputs are registered status. There is no data stream at the edge of the block, so there is no valid/ready handshake and no back-pressure. Every strobe is taken in the cycle it is high.

Top module: `i2c_xfer_counter`

## Requirements
- R1: While reset is held, and after it is released, `count_o` is 0, `thresh_flag_o` is 0 and `stop_req_o` is 0.
- R2: A bit strobe with index 1 (`bit_idx_i == 1`) while `addr_phase_i` is 0 raises `count_o` by exactly one, visible one cycle later. No other bit index of a normal byte changes the count.
- R3: Bit strobes while `addr_phase_i` is 1 never change `count_o`.
- R4: `start_i` clears `count_o` and `thresh_flag_o` in the next cycle. It cancels a pending STOP request and takes priority over every other input in the same cycle.
- R5: `count_o` saturates at 2^CNT_W-1 and never wraps to zero.
- R6: A data byte adds at most one to the count between two `byte_done_i` strobes. If `arb_lost_i` pulses while the first bit (index 0) of a data byte is in progress, the next bit strobe of that byte counts, whatever index it carries.
- R7: `thresh_flag_o` becomes 1 in the cycle after an increment makes `count_o` equal to a nonzero `thresh_i`, and only when `astp_mode_i` is `01` or `10`. This holds in both roles. A threshold of 0, or mode `00` or `11`, never sets it.
- R8: `thresh_flag_o` stays set until `flag_clr_i` or `start_i`. If a set and `flag_clr_i` fall in the same cycle, the set wins.
- R9: With `ctrl_mode_i` = 1 and `astp_mode_i` = `10`, `stop_req_o` is high for exactly one cycle. That cycle follows the `byte_done_i` strobe of the byte whose increment made the count equal to a nonzero threshold. In target mode, or in any other mode, it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | START or repeated START detected (strobe) |
| bit_stb_i | input | 1 | One bit position has been sampled (strobe) |
| bit_idx_i | input | IDX_W | Index of that bit in the byte, 0 = first, 8 = ACK slot |
| addr_phase_i | input | 1 | High while the current byte is an address byte |
| arb_lost_i | input | 1 | Arbitration lost (strobe) |
| byte_done_i | input | 1 | Byte finished, after its ACK/NACK bit (strobe) |
| thresh_i | input | CNT_W | Byte count threshold, 0 disables |
| astp_mode_i | input | 2 | 00 off, 01 flag, 10 flag plus automatic STOP, 11 off |
| ctrl_mode_i | input | 1 | 1 = controller role, 0 = target role |
| flag_clr_i | input | 1 | Clears the threshold flag (strobe) |
| count_o | output | CNT_W | Current data byte count |
| thresh_flag_o | output | 1 | Sticky threshold-reached flag |
| stop_req_o | output | 1 | One-cycle automatic STOP request |

## Verification
The bench builds the block with CNT_W = 4, IDX_W = 4 and the counting bit at index 1. This makes every threshold value from 0 to 15 reachable, along with the saturation point at 15, within 17 bytes. It sweeps all 16 thresholds against all four mode codes and both roles. For each byte it predicts the count, the flag and the STOP pulse from the byte number alone. Directed sequences then cover the arbitration-lost path, a repeated first-bit strobe, a START in the middle of a transfer, an address byte in the middle of a transfer, and a flag clear that lands in the same cycle as a flag set.

// File: rtl/i2c_xfer_counter_pkg.sv
package i2c_xfer_counter_pkg;

  typedef enum logic [1:0] {
    ASTP_OFF  = 2'b00,
    ASTP_FLAG = 2'b01,
    ASTP_STOP = 2'b10,
    ASTP_RSVD = 2'b11
  } astp_mode_e;

  function automatic logic flag_enabled(input astp_mode_e m);
    return (m == ASTP_FLAG) || (m == ASTP_STOP);
  endfunction

  function automatic logic stop_enabled(input astp_mode_e m, input logic ctrl);
    return ctrl && (m == ASTP_STOP);
  endfunction

endpackage

// File: rtl/i2c_byte_tracker.sv
module i2c_byte_tracker #(
  parameter int IDX_W   = 4,
  parameter int CNT_BIT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             bit_stb_i,
  input  logic [IDX_W-1:0] bit_idx_i,
  input  logic             addr_phase_i,
  input  logic             arb_lost_i,
  input  logic             byte_done_i,
  output logic             cnt_evt_o
);

  localparam logic [IDX_W-1:0] CNT_IDX   = IDX_W'(CNT_BIT);
  localparam logic [IDX_W-1:0] FIRST_IDX = '0;

  logic first_bit_q;   // first bit of a data byte in progress
  logic pend_q;        // arbitration lost during that first bit
  logic counted_q;     // current byte already counted

  assign cnt_evt_o = bit_stb_i && !addr_phase_i && !counted_q && !start_i &&
                     ((bit_idx_i == CNT_IDX) || pend_q);

  always_ff @(posedge clk) begin
    if (!rst_n || start_i) begin
      first_bit_q <= 1'b0;
      pend_q      <= 1'b0;
      counted_q   <= 1'b0;
    end else begin
      if (bit_stb_i) begin
        first_bit_q <= (bit_idx_i == FIRST_IDX) && !addr_phase_i;
        pend_q      <= 1'b0;
      end else if (arb_lost_i && first_bit_q) begin
        pend_q <= 1'b1;
      end
      if (cnt_evt_o) counted_q <= 1'b1;
      if (byte_done_i) begin
        counted_q   <= 1'b0;
        first_bit_q <= 1'b0;
        pend_q      <= 1'b0;
      end
    end
  end

  // a counted byte yields no further event until the byte closes
  AST_ONE_PER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_evt_o && !byte_done_i) |=> !cnt_evt_o || $past(byte_done_i)) else $error("one event per byte"); // R6

endmodule

// File: rtl/i2c_sat_counter.sv
module i2c_sat_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         bump_o
);

  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q;

  assign bump_o = inc_i && !clr_i && (cnt_q != CNT_MAX);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (bump_o) cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1)) else $error("count step"); // R2

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0)) else $error("count clear"); // R4

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !clr_i) |=> (cnt_q == CNT_MAX)) else $error("count wrapped"); // R5

endmodule

// File: rtl/i2c_thresh_stop.sv
module i2c_thresh_stop
  import i2c_xfer_counter_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         flag_clr_i,
  input  logic         byte_done_i,
  input  logic         bump_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] thr_i,
  input  logic [1:0]   mode_i,
  input  logic         ctrl_i,
  output logic         flag_o,
  output logic         stop_o
);

  astp_mode_e mode;
  logic [W-1:0] next_cnt;
  logic reach;
  logic flag_q, hit_q, stop_q;

  assign mode     = astp_mode_e'(mode_i);
  assign next_cnt = cnt_i + 1'b1;
  assign reach    = bump_i && (thr_i != '0) && (next_cnt == thr_i) && flag_enabled(mode);

  always_ff @(posedge clk) begin
    if (!rst_n || start_i) begin
      flag_q <= 1'b0;
      hit_q  <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      if (reach)           flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;

      if (reach && stop_enabled(mode, ctrl_i)) hit_q <= 1'b1;
      else if (byte_done_i)                    hit_q <= 1'b0;

      stop_q <= byte_done_i && hit_q;
    end
  end

  assign flag_o = flag_q;
  assign stop_o = stop_q;

  AST_STOP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |=> !stop_q) else $error("stop longer than a cycle"); // R9

  AST_STOP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |-> $past(byte_done_i)) else $error("stop without byte end"); // R9

  AST_FLAG_NEEDS_THR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> ($past(thr_i) != '0) && $past(bump_i)) else $error("flag without threshold"); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr_i && !start_i) |=> flag_q) else $error("flag dropped"); // R8

endmodule

// File: rtl/i2c_xfer_counter.sv
module i2c_xfer_counter
  import i2c_xfer_counter_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int IDX_W   = 4,
  parameter int CNT_BIT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             bit_stb_i,
  input  logic [IDX_W-1:0] bit_idx_i,
  input  logic             addr_phase_i,
  input  logic             arb_lost_i,
  input  logic             byte_done_i,
  input  logic [CNT_W-1:0] thresh_i,
  input  logic [1:0]       astp_mode_i,
  input  logic             ctrl_mode_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             thresh_flag_o,
  output logic             stop_req_o
);

  logic cnt_evt;
  logic bump;

  i2c_byte_tracker #(
    .IDX_W  (IDX_W),
    .CNT_BIT(CNT_BIT)
  ) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .bit_stb_i   (bit_stb_i),
    .bit_idx_i   (bit_idx_i),
    .addr_phase_i(addr_phase_i),
    .arb_lost_i  (arb_lost_i),
    .byte_done_i (byte_done_i),
    .cnt_evt_o   (cnt_evt)
  );

  i2c_sat_counter #(
    .W(CNT_W)
  ) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (start_i),
    .inc_i (cnt_evt),
    .cnt_o (count_o),
    .bump_o(bump)
  );

  i2c_thresh_stop #(
    .W(CNT_W)
  ) u_thr (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .flag_clr_i (flag_clr_i),
    .byte_done_i(byte_done_i),
    .bump_i     (bump),
    .cnt_i      (count_o),
    .thr_i      (thresh_i),
    .mode_i     (astp_mode_i),
    .ctrl_i     (ctrl_mode_i),
    .flag_o     (thresh_flag_o),
    .stop_o     (stop_req_o)
  );

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb_i && addr_phase_i && !start_i) |=> (count_o == $past(count_o))) else $error("address counted"); // R3

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (count_o == '0) && !thresh_flag_o && !stop_req_o) else $error("start did not clear"); // R4

endmodule

// File: tb/i2c_xfer_counter_test.sv
`timescale 1ns/1ps
module i2c_xfer_counter_test;

  localparam int CW = 4;
  localparam int IW = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 0, bit_stb = 0, addr_phase = 0, arb_lost = 0, byte_done = 0;
  logic flag_clr = 0, ctrl = 0;
  logic [IW-1:0] bit_idx = '0;
  logic [CW-1:0] thr = '0;
  logic [1:0] mode = 2'b00;
  logic [CW-1:0] count;
  logic flag, stop;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  i2c_xfer_counter #(.CNT_W(CW), .IDX_W(IW), .CNT_BIT(1)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .bit_stb_i(bit_stb),
    .bit_idx_i(bit_idx), .addr_phase_i(addr_phase), .arb_lost_i(arb_lost),
    .byte_done_i(byte_done), .thresh_i(thr), .astp_mode_i(mode),
    .ctrl_mode_i(ctrl), .flag_clr_i(flag_clr), .count_o(count),
    .thresh_flag_o(flag), .stop_req_o(stop)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk("R4", "count after start", int'(count), 0);
    chk("R4", "flag after start", int'(flag), 0);
  endtask

  task automatic bit_pulse(input int idx);
    @(negedge clk); bit_stb = 1; bit_idx = IW'(idx);
    @(negedge clk); bit_stb = 0;
  endtask

  task automatic end_byte(input int exp_stop, input int exp_flag);
    @(negedge clk); byte_done = 1;
    @(negedge clk); byte_done = 0; addr_phase = 0;
    chk("R9", "stop at byte end", int'(stop), exp_stop);
    chk("R7", "flag at byte end", int'(flag), exp_flag);
    @(negedge clk);
    chk("R9", "stop single cycle", int'(stop), 0);
  endtask

  task automatic send_byte(input bit is_addr, input int exp_cnt, input int exp_stop, input int exp_flag);
    string req;
    req = is_addr ? "R3" : ((exp_cnt == CMAX) ? "R5" : "R2");
    addr_phase = is_addr;
    for (int b = 0; b < 9; b++) begin
      bit_pulse(b);
      if (b == 1 || b == 8) chk(req, "count during byte", int'(count), exp_cnt);
    end
    end_byte(exp_stop, exp_flag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "count in reset", int'(count), 0);
    chk("R1", "stop in reset", int'(stop), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "count after reset", int'(count), 0);
    chk("R1", "flag after reset", int'(flag), 0);

    // sweep: every mode, both roles, every threshold
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 2; c++) begin
        for (int t = 0; t <= CMAX; t++) begin
          mode = 2'(m); ctrl = c[0]; thr = CW'(t);
          do_start();
          send_byte(1'b1, 0, 0, 0);
          for (int k = 1; k <= CMAX + 2; k++) begin
            int ec, es, ef;
            ec = (k > CMAX) ? CMAX : k;
            ef = ((m == 1 || m == 2) && t != 0 && k >= t) ? 1 : 0;
            es = (c == 1 && m == 2 && t != 0 && k == t) ? 1 : 0;
            send_byte(1'b0, ec, es, ef);
          end
        end
      end
    end

    // R6: arbitration lost during first bit, engine re-indexes
    mode = 2'b10; ctrl = 1; thr = 4'd2;
    do_start();
    send_byte(1'b1, 0, 0, 0);
    send_byte(1'b0, 1, 0, 0);
    bit_pulse(0);
    @(negedge clk); arb_lost = 1;
    @(negedge clk); arb_lost = 0;
    bit_pulse(0);
    chk("R6", "count after arb loss", int'(count), 2);
    bit_pulse(1);
    chk("R6", "no second count in byte", int'(count), 2);
    end_byte(1, 1);

    // R6: repeated first-bit strobe without arbitration loss does not count
    thr = 4'd0;
    do_start();
    bit_pulse(0); bit_pulse(0);
    chk("R6", "first bit alone", int'(count), 0);
    bit_pulse(1);
    chk("R2", "second bit counts", int'(count), 1);
    end_byte(0, 0);

    // R3: address byte in mid-transfer leaves count alone
    send_byte(1'b1, 1, 0, 0);
    send_byte(1'b0, 2, 0, 0);

    // R4: start mid-transfer clears count and flag
    mode = 2'b01; thr = 4'd1;
    do_start();
    send_byte(1'b0, 1, 0, 1);
    send_byte(1'b0, 2, 0, 1);
    bit_pulse(0);
    do_start();

    // R8: clear, then set and clear together
    send_byte(1'b0, 1, 0, 1);
    @(negedge clk); flag_clr = 1;
    @(negedge clk); flag_clr = 0;
    chk("R8", "flag cleared", int'(flag), 0);
    send_byte(1'b0, 2, 0, 0);
    do_start();
    @(negedge clk); bit_stb = 1; bit_idx = 4'd1; flag_clr = 1;
    @(negedge clk); bit_stb = 0; flag_clr = 0;
    chk("R8", "set wins over clear", int'(flag), 1);
    end_byte(0, 1);
    repeat (4) @(negedge clk);
    chk("R8", "flag sticky", int'(flag), 1);

    // R9: target role never requests stop in mode 10
    mode = 2'b10; ctrl = 0; thr = 4'd1;
    do_start();
    send_byte(1'b0, 1, 0, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule